// File: doc/BRIEF.md
# Frame-Slip Elastic Store

This block is the receive-side elastic buffer for a framed byte stream in which each frame carries 32 time slots of 8 bits (256 bits, one frame every 125 us at 2.048 Mbit/s). Bytes arrive on a recovered line clock, which may be off by up to ±50 ppm, and leave on the local system clock. The buffer holds a whole number of frames, 2, 4 or 8, and absorbs the slow phase drift between the two clocks.

The write pointer crosses into the read domain as a Gray code through a two-flop synchroniser. The read side derives the fill level from it. At each read-side frame boundary, the read side checks that fill against one quarter and three quarters of the capacity. If the fill is above the upper level, one whole frame is dropped. If it is below the lower level, the frame just read is played again. Time slot 0 therefore always comes out aligned with the output frame marker. A one-cycle pulse and a sticky flag report each kind of slip. The sticky flags are cleared from the read side.

Top module: `frame_slip_store`

## Requirements
- R1: `rd_vld` is high exactly one read cycle after a cycle with `rd_en` high, and `rd_sof` is high exactly on the output bytes that come from time slot 0.
- R2: Writes presented before the first `wr_sof` after reset are discarded. The byte carrying the first `wr_sof` is stored as slot 0 of the first frame.
- R3: After reset the read pointer sits half the capacity behind the write pointer. The first FRAMES/2 output frames are stale, and the next output frame begins with the first byte written.
- R4: With equal write and read rates, no slip happens and successive output frames are successive written frames. In the test stream each byte carries {frame count mod 8 in bits 7:5, slot number in bits 4:0}.
- R5: If the measured fill exceeds 3/4 of capacity when the last slot of a frame is read, the following written frame is skipped, so the frame count advances by 2. `del_pulse` is high in the same cycle as that last-slot byte.
- R6: If the measured fill is below 1/4 of capacity at the same point, the frame just read is output again, with the same frame count. `rep_pulse` is high in the same cycle as its last-slot byte.
- R7: Slips move the read pointer only from slot 31 to the start of a frame. Every output frame has 32 bytes from one written frame, in slot order.
- R8: `del_pulse` and `rep_pulse` each last one cycle per slip and are never high together.
- R9: `del_seen` and `rep_seen` go high with their pulse and stay high until `slip_clr` is sampled. They are low in the following cycle unless a new slip of that kind happens in the same cycle as the clear, in which case the slip wins.
- R10: The write pointer is sent to the read domain in Gray code, changing by at most one bit per write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered line clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write byte strobe |
| wr_sof | input | 1 | Marks the slot-0 byte of an input frame |
| wr_data | input | SLOT_W | Input byte |
| rclk | input | 1 | Local system clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read byte strobe |
| slip_clr | input | 1 | Clears both sticky slip flags |
| rd_data | output | SLOT_W | Realigned output byte |
| rd_sof | output | 1 | Output byte is slot 0 |
| rd_vld | output | 1 | Output byte valid |
| del_pulse | output | 1 | One-cycle pulse for a frame deletion |
| rep_pulse | output | 1 | One-cycle pulse for a frame repetition |
| del_seen | output | 1 | Sticky deletion flag |
| rep_seen | output | 1 | Sticky repetition flag |

## Verification
Output bytes, `rd_sof` and `rd_vld` change at the read edge that samples `rd_en`. The slip pulses and sticky flags change at the same edge as the last-slot byte, and a clear acts one edge after it is sampled. The bench drives inputs and samples outputs on the falling edge, and it compares `rd_vld` against the `rd_en` it captured on the previous rising edge. The measured fill trails the writes by about three read cycles, so the bench does not predict the exact cycle of a slip. Instead it checks where each pulse falls in the byte stream and what the next frame count is, against rates chosen to force each kind of slip.

// File: rtl/frame_slip_store.sv
`timescale 1ns/1ps
module frame_slip_store #(
  parameter int SLOT_W = 8,
  parameter int SLOTS  = 32,
  parameter int FRAMES = 4
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic              slip_clr,
  output logic [SLOT_W-1:0] rd_data,
  output logic              rd_sof,
  output logic              rd_vld,
  output logic              del_pulse,
  output logic              rep_pulse,
  output logic              del_seen,
  output logic              rep_seen
);
  localparam int DEPTH = SLOTS * FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int SB    = $clog2(SLOTS);
  localparam int HI    = DEPTH * 3 / 4;
  localparam int LO    = DEPTH / 4;

  logic [SLOT_W-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wsync1, wsync2, wsync_bin, rptr, rptr_nx, fill;
  logic locked, boundary, do_del, do_rep;

  // write domain
  wire       wr_go   = wr_en && (locked || wr_sof);
  wire [AW:0] wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      locked <= 1'b0;
    end else if (wr_go) begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      locked <= 1'b1;
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $onehot0(wgray ^ $past(wgray)));

  // read domain
  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) {wsync2, wsync1} <= '0;
    else         {wsync2, wsync1} <= {wsync1, wgray};

  always_comb
    for (int i = 0; i <= AW; i++) wsync_bin[i] = ^(wsync2 >> i);

  assign fill     = wsync_bin - rptr;
  assign boundary = rd_en && (rptr[SB-1:0] == SB'(SLOTS - 1));
  assign do_del   = boundary && (fill > (AW+1)'(HI));
  assign do_rep   = boundary && (fill < (AW+1)'(LO)) && !do_del;
  assign rptr_nx  = rptr + (AW+1)'(1)
                  + (do_del ? (AW+1)'(SLOTS) : '0)
                  - (do_rep ? (AW+1)'(SLOTS) : '0);

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rptr      <= (AW+1)'(2 * DEPTH - DEPTH / 2);
      rd_sof    <= 1'b0;
      rd_vld    <= 1'b0;
      del_pulse <= 1'b0;
      rep_pulse <= 1'b0;
      del_seen  <= 1'b0;
      rep_seen  <= 1'b0;
    end else begin
      rd_vld    <= rd_en;
      del_pulse <= do_del;
      rep_pulse <= do_rep;
      del_seen  <= (del_seen && !slip_clr) || do_del;
      rep_seen  <= (rep_seen && !slip_clr) || do_rep;
      if (rd_en) begin
        rptr   <= rptr_nx;
        rd_sof <= (rptr[SB-1:0] == '0);
      end
    end

  always_ff @(posedge rclk)
    if (rd_en) rd_data <= mem[rptr[AW-1:0]];

  // R7
  slip_aligned_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (del_pulse || rep_pulse) |-> (rptr[SB-1:0] == '0 && rd_vld));
  // R8
  pulse_excl_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(del_pulse && rep_pulse));
  // R9
  del_sticky_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    del_pulse |-> del_seen);
  // R9
  rep_sticky_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rep_pulse |-> rep_seen);
  // R9
  clr_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    slip_clr |=> ((!del_seen || del_pulse) && (!rep_seen || rep_pulse)));
  // R5
  fill_bound_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    fill <= (AW+1)'(DEPTH));
endmodule

// File: tb/frame_slip_store_tb.sv
`timescale 1ns/1ps
module frame_slip_store_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sof = 0, rd_en = 0, slip_clr = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_sof, rd_vld, del_pulse, rep_pulse, del_seen, rep_seen;

  int checks = 0, errors = 0;
  bit finished = 0, mon_on = 0;
  int ndel = 0, nrep = 0, nfr = 0;
  int step = 1, exp_slot = 0;
  logic [2:0] prev_fr = '0, wfr = '0;
  logic [4:0] wslot = '0;
  logic en_q = 0, prev_del = 0, prev_rep = 0;

  always #10 clk = ~clk;

  frame_slip_store u_dut (
    .wclk(clk), .wrst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof), .wr_data(wr_data),
    .rclk(clk), .rrst_n(rst_n), .rd_en(rd_en), .slip_clr(slip_clr),
    .rd_data(rd_data), .rd_sof(rd_sof), .rd_vld(rd_vld),
    .del_pulse(del_pulse), .rep_pulse(rep_pulse),
    .del_seen(del_seen), .rep_seen(rep_seen));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit pat(input int mode, input int c);
    case (mode)
      0: return (c % 2) == 0;
      1: return 1'b1;
      2: return (c % 4) != 3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input int cycles, input int wmode, input int rmode);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      rd_en = pat(rmode, c);
      wr_en = pat(wmode, c);
      if (wr_en) begin
        wr_data = {wfr, wslot};
        wr_sof  = (wslot == 0);
        if (wslot == 5'd31) wfr = wfr + 3'd1;
        wslot = wslot + 5'd1;
      end else wr_sof = 1'b0;
    end
  endtask

  always @(posedge clk) en_q <= rd_en;

  always @(negedge clk) if (mon_on) begin
    chk(rd_vld == en_q, "R1 rd_vld follows rd_en", rd_vld, en_q);
    if (del_pulse) begin
      ndel++;
      chk(rd_vld && rd_data[4:0] == 5'd31, "R5 delete at last slot", rd_data[4:0], 31);
      step = 2;
    end
    if (rep_pulse) begin
      nrep++;
      chk(rd_vld && rd_data[4:0] == 5'd31, "R6 repeat at last slot", rd_data[4:0], 31);
      step = 0;
    end
    if (del_pulse && rep_pulse) chk(0, "R8 pulses together", 1, 0);
    if ((del_pulse && prev_del) || (rep_pulse && prev_rep)) chk(0, "R8 pulse longer than one cycle", 2, 1);
    prev_del = del_pulse;
    prev_rep = rep_pulse;
    if (rd_vld) begin
      if (rd_sof) nfr++;
      if (nfr >= 3) begin
        chk(rd_sof == (rd_data[4:0] == 0), "R1 rd_sof on slot 0", rd_sof, rd_data[4:0] == 0);
        if (rd_sof) begin
          if (nfr == 3) begin
            chk(rd_data == 8'h00, "R2 first written byte is slot 0 of frame 0", rd_data, 0);
            chk(rd_data[7:5] == 3'd0, "R3 first fresh frame after FRAMES/2 stale", rd_data[7:5], 0);
          end else
            chk(rd_data[7:5] == 3'(prev_fr + 3'(step)), "R4 R5 R6 frame sequence",
                rd_data[7:5], 3'(prev_fr + 3'(step)));
          prev_fr  = rd_data[7:5];
          step     = 1;
          exp_slot = 0;
        end
        chk(rd_data[4:0] == 5'(exp_slot) && rd_data[7:5] == prev_fr, "R7 frame intact",
            rd_data, {prev_fr, 5'(exp_slot)});
        exp_slot++;
      end
    end
  end

  initial begin
    int d0, r0;
    repeat (5) @(negedge clk);
    chk(!rd_vld && !del_pulse && !rep_pulse, "R1 reset outputs idle", rd_vld, 0);
    chk(!del_seen && !rep_seen, "R9 sticky clear at reset", {del_seen, rep_seen}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    // junk before first marker (R2)
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sof = 1'b0; wr_data = 8'hFF;
    end
    run(1920, 0, 0);
    chk(ndel == 0 && nrep == 0, "R4 no slip at equal rates", ndel + nrep, 0);
    d0 = ndel; r0 = nrep;
    run(2000, 1, 2);
    chk(ndel > d0, "R5 deletions with fast writer", ndel - d0, 1);
    chk(nrep == r0, "R5 no repeat with fast writer", nrep - r0, 0);
    run(600, 0, 0);
    d0 = ndel; r0 = nrep;
    run(2000, 2, 1);
    chk(nrep > r0, "R6 repeats with slow writer", nrep - r0, 1);
    chk(ndel == d0, "R6 no delete with slow writer", ndel - d0, 0);
    @(negedge clk); wr_en = 0; wr_sof = 0; rd_en = 0;
    repeat (4) @(negedge clk);
    chk(del_seen && rep_seen, "R9 sticky set", {del_seen, rep_seen}, 3);
    slip_clr = 1'b1;
    @(negedge clk); slip_clr = 1'b0;
    chk(!del_seen && !rep_seen, "R9 sticky cleared", {del_seen, rep_seen}, 0);
    chk(nfr > 100, "R7 frames observed", nfr, 100);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule